// File: doc/BRIEF.md
# Shift-Register Random Generator with Byte CRC16

This block holds one 16-bit linear feedback shift register that serves two jobs. As a pseudo-random source it advances by a burst of 13 shifts at a time. As a checksum engine it folds one data byte into a CRC16 each time the high-byte register is written, most significant bit first. Both jobs use the polynomial x^16+x^15+x^2+1 (constant 0x8005) and the same register.

Software reaches the register through a byte-wide write port with separate low and high strobes, plus two read buses that always show the two halves. A write to the low byte moves the old low half up into the high half and loads the new byte at the bottom, so two low writes in a row set the whole register to a chosen seed. A 2-bit mode field picks free running, a single advance that clears itself, or a stopped register.

Top module: `lfsr_crc_engine`

## Requirements
- R1: While reset is asserted and after its release edge, the register holds the seed 0xACE1 and the mode field reads 00.
- R2: rd_lo always shows register bits 7:0 and rd_hi always shows bits 15:8.
- R3: A clock edge with wr_lo high sets the register to {old bits 7:0, wr_data}.
- R4: A clock edge with wr_hi high and wr_lo low folds wr_data into the register in one cycle. For each data bit from bit 7 down to bit 0, f = reg[15] XOR bit, reg = (reg << 1) XOR (f ? 0x8005 : 0). When wr_lo and wr_hi are both high, the low-byte write of R3 wins.
- R5: In mode 00, every clock edge with neither wr_lo nor wr_hi applies one advance: 13 of the shifts of R4 with a data bit of 0.
- R6: In mode 01, the first edge with no data write applies one advance and the mode field returns to 00 on that edge.
- R7: In mode 11 the register changes only through wr_lo or wr_hi.
- R8: Mode 10 behaves exactly like mode 11.
- R9: An edge with a data write applies no advance. In mode 01 the pending advance waits for the next edge without a write, and the mode stays 01.
- R10: An edge with mode_wr high loads mode_in into the mode field, overriding the self-clear of R6. The advance on that edge follows the mode held before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_lo | input | 1 | Low-byte write strobe (seed shift) |
| wr_hi | input | 1 | High-byte write strobe (CRC byte update) |
| wr_data | input | 8 | Byte to write |
| mode_wr | input | 1 | Mode field write strobe |
| mode_in | input | 2 | New mode value: 00 run, 01 single step, 10 and 11 stopped |
| mode_out | output | 2 | Current mode field |
| rd_lo | output | 8 | Register bits 7:0 |
| rd_hi | output | 8 | Register bits 15:8 |

## Verification
A behavioural model of the register and mode field is compared on every cycle against a directed series of patterns. Back-to-back low writes show that the seed shift moves the right half. A sequence of CRC bytes with varied bit patterns exposes bit-order or polynomial errors, which a single byte could hide. Runs of idle cycles in each of the four modes separate running, single step and the two stopped codes. Collisions follow: a write with an advance, a write with a pending single step, a mode write with a self-clear, and both strobes at once. These show which action wins each conflict. A long pseudo-random mix of all strobes then covers orderings that the directed steps miss.

// File: rtl/lfsr_crc_pkg.sv
package lfsr_crc_pkg;
   typedef enum logic [1:0] {
      MODE_RUN  = 2'b00,
      MODE_STEP = 2'b01,
      MODE_RSVD = 2'b10,
      MODE_HALT = 2'b11
   } lfsr_mode_e;
endpackage

// File: rtl/lfsr_shift_chain.sv
module lfsr_shift_chain #(
   parameter int               WIDTH  = 16,
   parameter logic [WIDTH-1:0] POLY   = 16'h8005,
   parameter int               STAGES = 8
) (
   input  logic [WIDTH-1:0]  state_i,
   input  logic [STAGES-1:0] data_i,
   output logic [WIDTH-1:0]  state_o
);
   logic [WIDTH-1:0] tap [0:STAGES];

   assign tap[0] = state_i;

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      logic fb;
      assign fb         = tap[k][WIDTH-1] ^ data_i[STAGES-1-k];
      assign tap[k+1]   = {tap[k][WIDTH-2:0], 1'b0} ^ (fb ? POLY : '0);
   end

   assign state_o = tap[STAGES];

   if (STAGES < 1) begin : g_bad_stages
      $error("lfsr_shift_chain: STAGES must be at least 1");
   end
   if (WIDTH < 2) begin : g_bad_width
      $error("lfsr_shift_chain: WIDTH must be at least 2");
   end
endmodule

// File: rtl/lfsr_mode_ctrl.sv
module lfsr_mode_ctrl
   import lfsr_crc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       data_wr,
   input  logic       mode_wr,
   input  logic [1:0] mode_in,
   output logic [1:0] mode_q,
   output logic       adv_en
);
   lfsr_mode_e cur_mode;
   logic       step_done;

   assign cur_mode  = lfsr_mode_e'(mode_q);
   assign adv_en    = !data_wr && (cur_mode == MODE_RUN || cur_mode == MODE_STEP);
   assign step_done = adv_en && (cur_mode == MODE_STEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_RUN;
      end else if (mode_wr) begin
         mode_q <= mode_in;
      end else if (step_done) begin
         mode_q <= MODE_RUN;
      end
   end

   // R6
   step_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'b01 && !data_wr && !mode_wr) |=> (mode_q == 2'b00));

   // R9
   step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'b01 && data_wr && !mode_wr) |=> (mode_q == 2'b01));

   // R10
   mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr |=> (mode_q == $past(mode_in)));
endmodule

// File: rtl/lfsr_crc_engine.sv
module lfsr_crc_engine #(
   parameter int               BYTE_W      = 8,
   parameter int               WIDTH       = 16,
   parameter logic [WIDTH-1:0] POLY        = 16'h8005,
   parameter int               RAND_UNROLL = 13,
   parameter logic [WIDTH-1:0] SEED        = 16'hACE1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              mode_wr,
   input  logic [1:0]        mode_in,
   output logic [1:0]        mode_out,
   output logic [BYTE_W-1:0] rd_lo,
   output logic [BYTE_W-1:0] rd_hi
);
   localparam int HALF = WIDTH / 2;

   logic [WIDTH-1:0] lfsr_q;
   logic [WIDTH-1:0] crc_next;
   logic [WIDTH-1:0] rand_next;
   logic             adv_en;
   logic             data_wr;

   if (WIDTH != 2 * BYTE_W) begin : g_bad_split
      $error("lfsr_crc_engine: WIDTH must be twice BYTE_W");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("lfsr_crc_engine: SEED must be non-zero");
   end
   if (RAND_UNROLL < 1) begin : g_bad_unroll
      $error("lfsr_crc_engine: RAND_UNROLL must be at least 1");
   end

   assign data_wr = wr_lo | wr_hi;

   lfsr_shift_chain #(.WIDTH(WIDTH), .POLY(POLY), .STAGES(BYTE_W)) u_crc_chain (
      .state_i (lfsr_q),
      .data_i  (wr_data),
      .state_o (crc_next)
   );

   lfsr_shift_chain #(.WIDTH(WIDTH), .POLY(POLY), .STAGES(RAND_UNROLL)) u_rand_chain (
      .state_i (lfsr_q),
      .data_i  ({RAND_UNROLL{1'b0}}),
      .state_o (rand_next)
   );

   lfsr_mode_ctrl u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .data_wr (data_wr),
      .mode_wr (mode_wr),
      .mode_in (mode_in),
      .mode_q  (mode_out),
      .adv_en  (adv_en)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lfsr_q <= SEED;
      end else if (wr_lo) begin
         lfsr_q <= {lfsr_q[HALF-1:0], wr_data};
      end else if (wr_hi) begin
         lfsr_q <= crc_next;
      end else if (adv_en) begin
         lfsr_q <= rand_next;
      end
   end

   assign rd_lo = lfsr_q[HALF-1:0];
   assign rd_hi = lfsr_q[WIDTH-1:HALF];

   // R3
   seed_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> (rd_hi == $past(rd_lo) && rd_lo == $past(wr_data)));

   // R7
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_out == 2'b11 && !wr_lo && !wr_hi) |=> $stable(lfsr_q));

   // R8
   rsvd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_out == 2'b10 && !wr_lo && !wr_hi) |=> $stable(lfsr_q));

   // R4
   crc_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi && !wr_lo) |=> (lfsr_q == $past(crc_next)));
endmodule

// File: tb/lfsr_crc_engine_tb.sv
module lfsr_crc_engine_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_lo = 1'b0;
   logic       wr_hi = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       mode_wr = 1'b0;
   logic [1:0] mode_in = 2'b00;
   logic [1:0] mode_out;
   logic [7:0] rd_lo;
   logic [7:0] rd_hi;

   int errors = 0;
   int checks = 0;
   int m_reg  = 16'hACE1;
   int m_mode = 0;
   int lcg    = 12345;

   always #2 clk = ~clk;

   lfsr_crc_engine u_dut (
      .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
      .mode_wr(mode_wr), .mode_in(mode_in), .mode_out(mode_out),
      .rd_lo(rd_lo), .rd_hi(rd_hi)
   );

   function automatic int shift1(int s, int b);
      int f;
      int r;
      f = ((s >> 15) & 1) ^ b;
      r = (s * 2) % 65536;
      if (f != 0) r = r ^ 32773;
      return r;
   endfunction

   task automatic check(string tag, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic compare(string tag);
      check({tag, " rd_lo"}, int'(rd_lo), m_reg % 256);
      check({tag, " rd_hi"}, int'(rd_hi), m_reg / 256);
      check({tag, " mode"}, int'(mode_out), m_mode);
   endtask

   // one clock: drive at negedge, update model, compare at next negedge
   task automatic cyc(string tag, bit lo, bit hi, int d, bit mw, int mi);
      bit idle;
      wr_lo = lo; wr_hi = hi; wr_data = d[7:0]; mode_wr = mw; mode_in = mi[1:0];
      idle = !lo && !hi;
      if (lo) begin
         m_reg = ((m_reg % 256) * 256) + (d % 256);
      end else if (hi) begin
         for (int i = 7; i >= 0; i--) m_reg = shift1(m_reg, (d >> i) & 1);
      end else if (m_mode == 0 || m_mode == 1) begin
         for (int i = 0; i < 13; i++) m_reg = shift1(m_reg, 0);
      end
      if (mw) m_mode = mi;
      else if (m_mode == 1 && idle) m_mode = 0;
      @(posedge clk);
      @(negedge clk);
      wr_lo = 1'b0; wr_hi = 1'b0; mode_wr = 1'b0;
      compare(tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      compare("R1 in reset");
      compare("R2 in reset");
      rst_n = 1'b1;
      // first cycle after release: mode 00 runs, also stop it
      cyc("R1 R5 first run", 0, 0, 0, 1, 3);
      for (int i = 0; i < 4; i++) cyc("R7 halt hold", 0, 0, 0, 0, 0);
      cyc("R3 seed a", 1, 0, 8'h12, 0, 0);
      cyc("R3 seed b", 1, 0, 8'h34, 0, 0);
      check("R3 full seed", {24'd0, rd_hi, rd_lo}, 16'h1234);
      check("R2 hi half", int'(rd_hi), 8'h12);
      cyc("R4 crc 00", 0, 1, 8'h00, 0, 0);
      cyc("R4 crc ff", 0, 1, 8'hFF, 0, 0);
      cyc("R4 crc a5", 0, 1, 8'hA5, 0, 0);
      cyc("R4 crc 80", 0, 1, 8'h80, 0, 0);
      cyc("R4 crc 01", 0, 1, 8'h01, 0, 0);
      cyc("R4 both strobes", 1, 1, 8'h5A, 0, 0);
      cyc("R8 enter rsvd", 0, 0, 0, 1, 2);
      for (int i = 0; i < 4; i++) cyc("R8 rsvd hold", 0, 0, 0, 0, 0);
      cyc("R8 write in rsvd", 0, 1, 8'h3C, 0, 0);
      cyc("R6 enter step", 0, 0, 0, 1, 1);
      cyc("R6 single step", 0, 0, 0, 0, 0);
      cyc("R6 now run", 0, 0, 0, 0, 0);
      for (int i = 0; i < 5; i++) cyc("R5 run", 0, 0, 0, 0, 0);
      cyc("R9 write over run", 1, 0, 8'h77, 0, 0);
      cyc("R9 crc over run", 0, 1, 8'hC3, 0, 0);
      cyc("R6 step again", 0, 0, 0, 1, 1);
      cyc("R9 step deferred lo", 1, 0, 8'h99, 0, 0);
      cyc("R9 step deferred hi", 0, 1, 8'h42, 0, 0);
      cyc("R9 step taken", 0, 0, 0, 0, 0);
      cyc("R10 to step", 0, 0, 0, 1, 1);
      cyc("R10 override clear", 0, 0, 0, 1, 3);
      cyc("R10 halt after", 0, 0, 0, 0, 0);
      cyc("R10 load run", 0, 0, 0, 1, 0);
      for (int i = 0; i < 400; i++) begin
         int r;
         lcg = (lcg * 1103515245 + 12345) & 32'h7FFFFFFF;
         r = lcg >> 8;
         cyc("R5 R9 mixed", (r % 7) == 0, (r % 5) == 0, (r >> 4) % 256,
             (r % 11) == 0, (r >> 12) % 4);
      end
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule